// File: doc/BRIEF.md
# Paged Program Address Sequencer

This block produces the instruction fetch address for a program store organised as 16 pages of 64 words. A 6-bit word counter supplies the low address bits and a 4-bit page register the high bits. Because an instruction cannot name both a page and a word, a page change is staged: a page buffer is written first, and its value moves into the page register only when a branch or call is actually taken.

Branch and call are gated by an external status flag; when the flag is clear they behave like a plain sequential fetch. A taken call saves the full return address (page and following word) on a three-entry return stack, and return restores both fields, so control can go back to a caller on another page. The surrounding decoder presents one instruction's strobes per advance cycle; with the advance strobe low the sequencer holds its state.

Top module: `pgseq_top`

## Requirements
- R1: The fetch address is {page register, word counter}: bits 9:6 are the page and bits 5:0 the word; after reset the address is 0.
- R2: An advance cycle with no taken branch, taken call or return adds 1 to the word counter, wrapping 63 to 0 without changing the page.
- R3: When the advance strobe is low, the address, the page buffer and the return stack do not change, whatever the other strobes are.
- R4: A load-buffer strobe writes the 4-bit page immediate into the page buffer only; in that cycle the page is unchanged and the word advances normally.
- R5: A branch or call with the status flag at 1 loads the page register from the page buffer and the word counter from the 6-bit target in the same cycle.
- R6: A branch or call with the status flag at 0 acts as a sequential advance: nothing is pushed and the page buffer keeps its value.
- R7: A taken call pushes {current page, current word + 1 modulo 64}; a call at word 63 saves word 0 of the same page.
- R8: A return (not conditional on the flag) loads both page and word from the newest stack entry and removes that entry.
- R9: The stack returns addresses in last-in first-out order over three levels; a fourth nested call discards the oldest entry.
- R10: A return with no saved entry (after reset, or after all entries were used) gives address 0.
- R11: When several strobes are set, return wins over call, and call over branch; a load-buffer in the same cycle as a taken branch lets the branch use the buffer's previous value, and the new value is kept for later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| step_i | input | 1 | Advance strobe: one instruction takes effect |
| ldbuf_i | input | 1 | Load page buffer from pgimm_i |
| jump_i | input | 1 | Branch strobe |
| call_i | input | 1 | Subroutine call strobe |
| ret_i | input | 1 | Return strobe |
| flag_i | input | 1 | Status flag gating branch and call |
| target_i | input | 6 | Word target of branch or call |
| pgimm_i | input | 4 | Page immediate for the page buffer |
| fetch_addr_o | output | 10 | Fetch address {page, word} |

## Verification
The hardest state to reach is a full stack whose oldest entry has just been discarded, with each saved entry on a different page, since only a fourth nested call from distinct pages reveals whether the right entry was dropped. The bench reaches it by loading a new page immediate before each of four taken calls, then unwinds with five returns, the last one exercising the empty-stack zero. Wrap of the pushed word is reached by branching to word 63 before a call, and every page value is swept through the buffer-then-branch pair.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;
  localparam int unsigned WORD_W_DEF = 6;
  localparam int unsigned PAGE_W_DEF = 4;
  localparam int unsigned DEPTH_DEF  = 3;

  // action applied to the address registers in one cycle
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_SEQ  = 2'd1,
    ACT_JUMP = 2'd2,
    ACT_RET  = 2'd3
  } act_e;
endpackage

// File: rtl/pgseq_word.sv
module pgseq_word
  import pgseq_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  act_e              act,
  input  logic [WORD_W-1:0] target,
  input  logic [WORD_W-1:0] ret_word,
  output logic [WORD_W-1:0] word_q,
  output logic [WORD_W-1:0] word_inc
);
  localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

  logic [WORD_W-1:0] word_d;
  logic              word_en;

  assign word_inc = word_q + ONE;

  always_comb begin
    word_en = 1'b1;
    word_d  = word_q;
    case (act)
      ACT_HOLD: word_en = 1'b0;
      ACT_SEQ:  word_d  = word_inc;
      ACT_JUMP: word_d  = target;
      ACT_RET:  word_d  = ret_word;
      default:  word_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end
endmodule

// File: rtl/pgseq_page.sv
module pgseq_page
  import pgseq_pkg::*;
#(
  parameter int unsigned PAGE_W = PAGE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  act_e              act,
  input  logic              ld_en,
  input  logic [PAGE_W-1:0] imm,
  input  logic [PAGE_W-1:0] ret_page,
  output logic [PAGE_W-1:0] page_q
);
  logic [PAGE_W-1:0] buf_q;
  logic [PAGE_W-1:0] page_d;
  logic              page_en;

  always_comb begin
    page_en = 1'b0;
    page_d  = page_q;
    case (act)
      ACT_JUMP: begin page_en = 1'b1; page_d = buf_q;    end
      ACT_RET:  begin page_en = 1'b1; page_d = ret_page; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       page_q <= '0;
    else if (page_en) page_q <= page_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     buf_q <= '0;
    else if (ld_en) buf_q <= imm;
  end
endmodule

// File: rtl/pgseq_stack.sv
module pgseq_stack #(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned ENT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [ENT_W-1:0] push_data,
  output logic [ENT_W-1:0] top
);
  logic [ENT_W-1:0] ent_q [DEPTH];
  logic [ENT_W-1:0] ent_d [DEPTH];
  logic             ent_en;

  assign ent_en = push | pop;
  assign top    = ent_q[0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (i == 0) begin : g_head
      always_comb ent_d[i] = push ? push_data
                                  : ((DEPTH > 1) ? ent_q[(DEPTH > 1) ? 1 : 0] : '0);
    end else if (i == DEPTH - 1) begin : g_tail
      always_comb ent_d[i] = push ? ent_q[i-1] : '0;
    end else begin : g_mid
      always_comb ent_d[i] = push ? ent_q[i-1] : ent_q[i+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q[i] <= '0;
      else if (ent_en) ent_q[i] <= ent_d[i];
    end
  end
endmodule

// File: rtl/pgseq_top.sv
module pgseq_top
  import pgseq_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned PAGE_W = PAGE_W_DEF,
  parameter int unsigned DEPTH  = DEPTH_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step_i,
  input  logic                     ldbuf_i,
  input  logic                     jump_i,
  input  logic                     call_i,
  input  logic                     ret_i,
  input  logic                     flag_i,
  input  logic [WORD_W-1:0]        target_i,
  input  logic [PAGE_W-1:0]        pgimm_i,
  output logic [WORD_W+PAGE_W-1:0] fetch_addr_o
);
  localparam int unsigned AW = WORD_W + PAGE_W;

  logic [1:0]        rst_sync_q;
  logic              run_n;
  logic              taken;
  logic              push;
  logic              pop;
  logic              ld_en;
  act_e              act;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_inc;
  logic [PAGE_W-1:0] page_q;
  logic [AW-1:0]     stk_top;

  // reset asserts at once, leaves after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign run_n = rst_sync_q[1];

  assign taken = flag_i & (jump_i | call_i);
  assign push  = step_i & ~ret_i & call_i & flag_i;
  assign pop   = step_i & ret_i;
  assign ld_en = step_i & ldbuf_i;

  always_comb begin
    if (!step_i)    act = ACT_HOLD;
    else if (ret_i) act = ACT_RET;
    else if (taken) act = ACT_JUMP;
    else            act = ACT_SEQ;
  end

  pgseq_word #(.WORD_W(WORD_W)) u_word (
    .clk      (clk),
    .rst_n    (run_n),
    .act      (act),
    .target   (target_i),
    .ret_word (stk_top[WORD_W-1:0]),
    .word_q   (word_q),
    .word_inc (word_inc)
  );

  pgseq_page #(.PAGE_W(PAGE_W)) u_page (
    .clk      (clk),
    .rst_n    (run_n),
    .act      (act),
    .ld_en    (ld_en),
    .imm      (pgimm_i),
    .ret_page (stk_top[AW-1:WORD_W]),
    .page_q   (page_q)
  );

  pgseq_stack #(.DEPTH(DEPTH), .ENT_W(AW)) u_stack (
    .clk       (clk),
    .rst_n     (run_n),
    .push      (push),
    .pop       (pop),
    .push_data ({page_q, word_inc}),
    .top       (stk_top)
  );

  assign fetch_addr_o = {page_q, word_q};
endmodule

// File: rtl/pgseq_chk.sv
module pgseq_chk #(
  parameter int unsigned WORD_W = 6,
  parameter int unsigned PAGE_W = 4
) (
  input logic                     clk,
  input logic                     run_n,
  input logic                     step_i,
  input logic                     ldbuf_i,
  input logic                     jump_i,
  input logic                     call_i,
  input logic                     ret_i,
  input logic                     flag_i,
  input logic [WORD_W-1:0]        target_i,
  input logic [WORD_W+PAGE_W-1:0] fetch_addr_o
);
  localparam int unsigned AW = WORD_W + PAGE_W;
  localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

  logic seq_cyc;
  logic jmp_cyc;
  assign jmp_cyc = step_i & ~ret_i & flag_i & (jump_i | call_i);
  assign seq_cyc = step_i & ~ret_i & ~jmp_cyc;

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!run_n)
    seq_cyc |=> (fetch_addr_o[WORD_W-1:0] == $past(fetch_addr_o[WORD_W-1:0]) + ONE)
             && (fetch_addr_o[AW-1:WORD_W] == $past(fetch_addr_o[AW-1:WORD_W])));

  // R3
  hold_addr_chk: assert property (@(posedge clk) disable iff (!run_n)
    !step_i |=> $stable(fetch_addr_o));

  // R4
  ldbuf_page_chk: assert property (@(posedge clk) disable iff (!run_n)
    (ldbuf_i && seq_cyc) |=> $stable(fetch_addr_o[AW-1:WORD_W]));

  // R5
  jump_word_chk: assert property (@(posedge clk) disable iff (!run_n)
    jmp_cyc |=> fetch_addr_o[WORD_W-1:0] == $past(target_i));

  // R6
  fall_thru_chk: assert property (@(posedge clk) disable iff (!run_n)
    (step_i && !ret_i && !flag_i && (jump_i || call_i))
      |=> fetch_addr_o[WORD_W-1:0] == $past(fetch_addr_o[WORD_W-1:0]) + ONE);
endmodule

bind pgseq_top pgseq_chk #(.WORD_W(WORD_W), .PAGE_W(PAGE_W)) u_chk (
  .clk          (clk),
  .run_n        (run_n),
  .step_i       (step_i),
  .ldbuf_i      (ldbuf_i),
  .jump_i       (jump_i),
  .call_i       (call_i),
  .ret_i        (ret_i),
  .flag_i       (flag_i),
  .target_i     (target_i),
  .fetch_addr_o (fetch_addr_o)
);

// File: tb/pgseq_top_test.sv
module pgseq_top_test;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       step_i, ldbuf_i, jump_i, call_i, ret_i, flag_i;
  logic [5:0] target_i;
  logic [3:0] pgimm_i;
  logic [9:0] fetch_addr_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // expected state, from the requirements
  logic [5:0] e_word;
  logic [3:0] e_page;
  logic [3:0] e_buf;
  logic [9:0] e_stk [3];

  pgseq_top uut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .ldbuf_i(ldbuf_i),
    .jump_i(jump_i), .call_i(call_i), .ret_i(ret_i), .flag_i(flag_i),
    .target_i(target_i), .pgimm_i(pgimm_i), .fetch_addr_o(fetch_addr_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req);
    logic [9:0] exp_a;
    exp_a = {e_page, e_word};
    n_chk++;
    if (fetch_addr_o !== exp_a) begin
      n_fail++;
      $display("FAIL %s: addr=%h expected=%h", req, fetch_addr_o, exp_a);
    end
  endtask

  // drive one cycle at a falling edge, predict, compare at the next falling edge
  task automatic op(input bit st, input bit ld, input bit jp, input bit cl,
                    input bit rt, input bit fl, input int tgt, input int imm,
                    input string req);
    step_i = st; ldbuf_i = ld; jump_i = jp; call_i = cl; ret_i = rt; flag_i = fl;
    target_i = 6'(tgt); pgimm_i = 4'(imm);
    if (st) begin
      if (rt) begin
        {e_page, e_word} = e_stk[0];
        e_stk[0] = e_stk[1]; e_stk[1] = e_stk[2]; e_stk[2] = '0;
      end else if (fl && (jp || cl)) begin
        if (cl) begin
          e_stk[2] = e_stk[1]; e_stk[1] = e_stk[0];
          e_stk[0] = {e_page, 6'(e_word + 6'd1)};
        end
        e_page = e_buf;
        e_word = 6'(tgt);
      end else begin
        e_word = e_word + 6'd1;
      end
      if (ld) e_buf = 4'(imm);
    end
    @(negedge clk);
    check(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    step_i = 0; ldbuf_i = 0; jump_i = 0; call_i = 0; ret_i = 0; flag_i = 0;
    target_i = '0; pgimm_i = '0;
    e_word = '0; e_page = '0; e_buf = '0;
    for (int i = 0; i < 3; i++) e_stk[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release");

    // R2: sweep through a full page and past the wrap
    for (int i = 0; i < 70; i++) op(1,0,0,0,0,0,0,0,"R2 sequential/wrap");

    // R3: strobes without advance have no effect
    for (int i = 0; i < 4; i++) op(0,1,1,1,i[0],1,i*7,9,"R3 hold");
    op(1,0,1,0,0,1,5,0,"R3 buffer untouched by held load");

    // R4 then R5: every page through buffer and taken branch
    for (int p = 0; p < 16; p++) begin
      op(1,1,0,0,0,0,0,p,"R4 load buffer only");
      op(1,0,1,0,0,1,(p*5+3)%64,0,"R5 taken branch");
    end

    // R6: not-taken branch and call, then show buffer and stack unchanged
    op(1,1,0,0,0,0,0,6,"R4 load buffer");
    op(1,0,1,0,0,0,12,0,"R6 branch flag 0");
    op(1,0,0,1,0,0,13,0,"R6 call flag 0");
    op(1,0,1,0,0,1,40,0,"R6 buffer kept");
    op(1,0,0,0,1,0,0,0,"R10 empty return after untaken call");

    // R7: call from word 63 saves word 0
    op(1,1,1,0,0,1,63,2,"R5 branch to 63");
    op(1,1,0,1,0,1,8,7,"R7 call at word 63");
    op(1,0,0,0,1,0,0,0,"R7 R8 return to wrapped word");

    // R9: four nested calls from distinct pages, five returns
    for (int k = 0; k < 4; k++) begin
      op(1,1,0,0,0,0,0,k+9,"R4 stage page");
      op(1,0,0,1,0,1,10*k+10,0,"R7 nested call");
    end
    op(1,0,0,0,1,1,0,0,"R9 return newest");
    op(1,0,0,0,1,0,0,0,"R9 return second");
    op(1,0,0,0,1,0,0,0,"R9 return third");
    op(1,0,0,0,1,0,0,0,"R10 oldest discarded, return zero");
    op(1,0,0,0,1,0,0,0,"R10 empty return");

    // R11: priority and same-cycle load with branch
    op(1,1,0,0,0,0,0,3,"R4 stage page");
    op(1,0,0,1,0,1,33,0,"R7 call");
    op(1,0,1,1,1,1,50,0,"R11 return wins");
    op(1,1,1,0,0,1,21,12,"R11 branch uses old buffer");
    op(1,0,1,1,0,1,44,0,"R11 call wins over branch, new buffer");
    op(1,0,0,0,1,0,0,0,"R8 return after priority call");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule